// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

A line-length storage buffer of 1152 bytes with a write port and a read port on two independent clocks. Each port walks its own address counter. The counter moves on when the port's active-low enable is sampled low, and it is forced to address zero by the port's active-low synchronous reset. The block has no occupancy tracking and raises no full or empty indication. The user sets the distance between the two counters by choosing when each side is reset or paused, and that distance is the delay the block provides.

A captured write byte sits in a one-entry holding stage and is committed to the array on the following write-clock edge. The read side registers the addressed word on its clock. It also registers an output-enable flag that stands in for a three-state output driver. Typical use is a one-line or shorter delay in a raster image pipeline. Both resets released together give a delay of exactly one line. Releasing them at different times, or holding the read side paused, gives a shorter delay.

Top module: `line_delay_mem`

## Requirements
- R1: A write-clock rising edge with `wr_en_n` low captures `wr_data` for the current write address and advances the write counter by one.
- R2: A write-clock rising edge with `wr_en_n` high captures nothing and leaves the write counter unchanged, so the next enabled byte goes to the following address.
- R3: A write-clock rising edge with `wr_rst_n` low uses address 0 for that cycle, so a byte enabled in that cycle is stored at address 0. The byte enabled after reset is released goes to address 1.
- R4: A read-clock rising edge with `rd_en_n` low loads the word at the current read address into `rd_data`, sets `rd_oe` to 1 and advances the read counter.
- R5: A read-clock rising edge with `rd_en_n` high clears `rd_oe` at that edge, keeps `rd_data` unchanged and holds the read counter.
- R6: While `rd_rst_n` is low with reading enabled, every read edge returns the word at address 0. After release, the words at addresses 1, 2 and onwards follow in order.
- R7: A captured byte is written into the array at the next write-clock edge after its capture. A read edge that falls between the capture edge and that next write edge returns the word the address held before.
- R8: Both counters wrap from address 1151 to address 0 when they advance.
- R9: With both resets applied in the same cycle and both ports enabled on clocks of equal rate, the byte written in cycle k appears on `rd_data` in cycle k+1152.
- R10: A read reset applied m cycles (m at least 3) after the write reset, with reading enabled from then on, gives a delay of m cycles.
- R11: Resetting both sides together and then holding `rd_en_n` high for m cycles (m at least 3) gives a delay of m cycles. `rd_oe` stays 0 while reading is held off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock, rising edge active |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write counter synchronous reset, active low |
| wr_data | input | WIDTH | Byte to store |
| rd_clk | input | 1 | Read-side clock, rising edge active, independent of `wr_clk` |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read counter synchronous reset, active low |
| rd_data | output | WIDTH | Registered read word |
| rd_oe | output | 1 | Output drive flag; 0 means the bus would float |

## Verification
Counter wrap is the hardest behaviour to reach from the ports. The write counter's wrap only shows when a read of address 0 returns a byte from the second pass, which takes more than two full lines of stimulus. The bench runs both sides from a common reset for 2306 cycles and checks the second-pass bytes at addresses 0 and 1. It also checks the write-to-read window of R7 by placing a read edge between a capture edge and its commit edge, which depends on the fixed phase offset between the two bench clocks.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

   // Address width needed to index a store of the given depth.
   function automatic int unsigned ldm_abits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   // True when the depth is a power of two, so natural overflow wraps.
   function automatic bit ldm_is_pow2(input int unsigned depth);
      return (depth != 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/ldm_addr_ctr.sv
module ldm_addr_ctr
   import ldm_pkg::*;
#(
   parameter int unsigned DEPTH = 1152,
   parameter int unsigned AW    = ldm_abits(DEPTH)
) (
   input  logic          clk,
   input  logic          en_n,
   input  logic          rst_n,
   output logic [AW-1:0] addr_now
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] cnt_q;
   logic [AW-1:0] addr_c;
   logic [AW-1:0] inc_c;
   logic          armed_q;

   generate
      if (AW != ldm_abits(DEPTH)) begin : g_bad_aw
         $error("ldm_addr_ctr: AW does not match DEPTH");
      end
   endgenerate

   // Address used this cycle: reset forces zero.
   assign addr_c = rst_n ? cnt_q : '0;

   generate
      if (ldm_is_pow2(DEPTH)) begin : g_wrap_pow2
         assign inc_c = addr_c + AW'(1);
      end else begin : g_wrap_cmp
         assign inc_c = (addr_c == LAST) ? '0 : (addr_c + AW'(1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      cnt_q <= en_n ? addr_c : inc_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b1;
   end

   assign addr_now = addr_c;

   // R2: a disabled edge with no reset keeps the counter
   p_hold_r2: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
      (en_n && rst_n) |=> (cnt_q == $past(cnt_q)));

   // R8: advancing from the last address lands on zero
   p_wrap_r8: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
      (!en_n && rst_n && cnt_q == LAST) |=> (cnt_q == '0));

   // R3: an enabled reset cycle uses address 0, so the next address is 1
   p_rst_next_r3: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
      (!en_n && !rst_n) |=> (cnt_q == AW'(1)));

endmodule

// File: rtl/ldm_wr_stage.sv
module ldm_wr_stage #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned AW    = 11
) (
   input  logic             clk,
   input  logic             en_n,
   input  logic [AW-1:0]    addr_now,
   input  logic [WIDTH-1:0] din,
   output logic             commit,
   output logic [AW-1:0]    commit_addr,
   output logic [WIDTH-1:0] commit_word
);

   logic             vld_q;
   logic [AW-1:0]    addr_q;
   logic [WIDTH-1:0] word_q;

   // One-entry holding stage: the captured byte lands on the next edge.
   always_ff @(posedge clk) begin
      vld_q <= ~en_n;
      if (!en_n) begin
         addr_q <= addr_now;
         word_q <= din;
      end
   end

   assign commit      = vld_q;
   assign commit_addr = addr_q;
   assign commit_word = word_q;

endmodule

// File: rtl/ldm_store.sv
module ldm_store #(
   parameter int unsigned DEPTH = 1152,
   parameter int unsigned WIDTH = 8,
   parameter int unsigned AW    = 11
) (
   input  logic             wclk,
   input  logic             wr_commit,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_word,
   input  logic             rclk,
   input  logic             rd_take,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_word
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (wr_commit) begin
         mem[wr_addr] <= wr_word;
         // R8: counters never address past the last word
         p_commit_range_r8: assert (32'(wr_addr) < DEPTH);
      end
   end

   always_ff @(posedge rclk) begin
      if (rd_take) begin
         rd_word <= mem[rd_addr];
         p_read_range_r8: assert (32'(rd_addr) < DEPTH);
      end
   end

endmodule

// File: rtl/ldm_rd_oe.sv
module ldm_rd_oe (
   input  logic clk,
   input  logic en_n,
   input  logic rst_n,
   output logic oe
);

   logic oe_q;
   logic armed_q;

   always_ff @(posedge clk) begin
      oe_q <= ~en_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b1;
   end

   assign oe = oe_q;

   // R4: an enabled read edge turns the output on
   p_oe_on_r4: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
      !en_n |=> oe);

   // R5: the first disabled edge turns the output off
   p_oe_off_r5: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
      en_n |=> !oe);

endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
   import ldm_pkg::*;
#(
   parameter int unsigned DEPTH = 1152,
   parameter int unsigned WIDTH = 8
) (
   input  logic             wr_clk,
   input  logic             wr_en_n,
   input  logic             wr_rst_n,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_clk,
   input  logic             rd_en_n,
   input  logic             rd_rst_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_oe
);

   localparam int unsigned AW = ldm_abits(DEPTH);

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("line_delay_mem: DEPTH must be at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("line_delay_mem: WIDTH must be at least 1");
      end
   endgenerate

   logic [AW-1:0]    waddr;
   logic [AW-1:0]    raddr;
   logic             commit;
   logic [AW-1:0]    commit_addr;
   logic [WIDTH-1:0] commit_word;
   logic             rd_armed_q;

   ldm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) i_wr_ctr (
      .clk(wr_clk), .en_n(wr_en_n), .rst_n(wr_rst_n), .addr_now(waddr)
   );

   ldm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) i_rd_ctr (
      .clk(rd_clk), .en_n(rd_en_n), .rst_n(rd_rst_n), .addr_now(raddr)
   );

   ldm_wr_stage #(.WIDTH(WIDTH), .AW(AW)) i_wr_stage (
      .clk(wr_clk), .en_n(wr_en_n), .addr_now(waddr), .din(wr_data),
      .commit(commit), .commit_addr(commit_addr), .commit_word(commit_word)
   );

   ldm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) i_store (
      .wclk(wr_clk), .wr_commit(commit), .wr_addr(commit_addr),
      .wr_word(commit_word), .rclk(rd_clk), .rd_take(~rd_en_n),
      .rd_addr(raddr), .rd_word(rd_data)
   );

   ldm_rd_oe i_rd_oe (
      .clk(rd_clk), .en_n(rd_en_n), .rst_n(rd_rst_n), .oe(rd_oe)
   );

   always_ff @(posedge rd_clk) begin
      if (!rd_rst_n) rd_armed_q <= 1'b1;
   end

   // R5: a disabled read edge leaves the output word unchanged
   p_rd_hold_r5: assert property (@(posedge rd_clk) disable iff (rd_armed_q !== 1'b1)
      rd_en_n |=> $stable(rd_data));

   // R6: a reset read edge with reading enabled selects address 0
   p_rst_addr0_r6: assert property (@(posedge rd_clk) disable iff (rd_armed_q !== 1'b1)
      (!rd_rst_n && !rd_en_n) |-> (raddr == '0));

endmodule

// File: tb/test_line_delay_mem.sv
module test_line_delay_mem;

   localparam int DEPTH = 1152;

   logic       wr_clk = 1'b0;
   logic       rd_clk = 1'b0;
   logic       wr_en_n = 1'b1;
   logic       wr_rst_n = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en_n = 1'b1;
   logic       rd_rst_n = 1'b1;
   logic [7:0] rd_data;
   logic       rd_oe;

   int checks = 0;
   int errors = 0;

   // 250 MHz write clock; read clock at the same rate, 1 ns behind.
   initial forever #2 wr_clk = ~wr_clk;
   initial begin
      #1;
      forever #2 rd_clk = ~rd_clk;
   end

   line_delay_mem #(.DEPTH(DEPTH), .WIDTH(8)) i_line_delay_mem (
      .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n),
      .rd_data(rd_data), .rd_oe(rd_oe)
   );

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'((i * 37 + s) ^ (i >> 7));
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One write edge followed by one read edge; sample 1 ns after the read edge.
   task automatic cyc(input logic we, input logic wrs, input logic [7:0] d,
                      input logic re, input logic rrs);
      wr_en_n = we; wr_rst_n = wrs; wr_data = d;
      rd_en_n = re; rd_rst_n = rrs;
      @(posedge wr_clk);
      @(posedge rd_clk);
      #1;
   endtask

   task automatic t_reset_state;
      cyc(1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
      chk("R5 reset state oe", int'(rd_oe), 0);
   endtask

   task automatic t_basic;
      cyc(1'b0, 1'b0, 8'hA0, 1'b1, 1'b1);
      for (int i = 1; i < 5; i++) cyc(1'b0, 1'b1, 8'hA0 + 8'(i), 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
      chk("R3/R6 addr0 word", int'(rd_data), 'hA0);
      chk("R4 oe on", int'(rd_oe), 1);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
      chk("R6 repeated reset word", int'(rd_data), 'hA0);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
      chk("R1/R6 word 1 after release", int'(rd_data), 'hA1);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
      chk("R4 word 2", int'(rd_data), 'hA2);
   endtask

   task automatic t_disable;
      cyc(1'b0, 1'b0, 8'hB0, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'hEE, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'hEE, 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 8'hB1, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
      chk("R3 word at addr0", int'(rd_data), 'hB0);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
      chk("R2 disabled bytes skipped", int'(rd_data), 'hB1);
      cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
      chk("R5 oe off", int'(rd_oe), 0);
      chk("R5 data held", int'(rd_data), 'hB1);
      cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
      chk("R5 counter held", int'(rd_data), 'hA2);
   endtask

   task automatic t_commit_window;
      cyc(1'b0, 1'b0, 8'hC0, 1'b0, 1'b0);
      chk("R7 read before commit sees old word", int'(rd_data), 'hB0);
      cyc(1'b0, 1'b1, 8'hC1, 1'b0, 1'b0);
      chk("R7 read after commit sees new word", int'(rd_data), 'hC0);
   endtask

   task automatic t_full_line;
      for (int i = 0; i < 2 * DEPTH + 2; i++) begin
         cyc(1'b0, (i == 0) ? 1'b0 : 1'b1, pat(i, 1), 1'b0, (i == 0) ? 1'b0 : 1'b1);
         if (i >= DEPTH && i < DEPTH + 4)
            chk("R9 one-line delay", int'(rd_data), int'(pat(i - DEPTH, 1)));
         if (i >= 2 * DEPTH)
            chk("R8 second pass after wrap", int'(rd_data), int'(pat(i - DEPTH, 1)));
      end
   endtask

   task automatic t_rst_offset;
      for (int i = 0; i < 12; i++) begin
         cyc(1'b0, (i == 0) ? 1'b0 : 1'b1, pat(i, 3),
             (i < 5) ? 1'b1 : 1'b0, (i == 5) ? 1'b0 : 1'b1);
         if (i >= 5 && i < 9)
            chk("R10 reset-offset delay", int'(rd_data), int'(pat(i - 5, 3)));
      end
   endtask

   task automatic t_en_offset;
      for (int i = 0; i < 12; i++) begin
         cyc(1'b0, (i == 0) ? 1'b0 : 1'b1, pat(i, 9),
             (i < 5) ? 1'b1 : 1'b0, (i == 0) ? 1'b0 : 1'b1);
         if (i == 3) chk("R11 oe off while paused", int'(rd_oe), 0);
         if (i >= 5 && i < 9)
            chk("R11 pause delay", int'(rd_data), int'(pat(i - 5, 9)));
      end
   endtask

   initial begin
      #200_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1;
      t_reset_state();
      t_basic();
      t_disable();
      t_commit_window();
      t_full_line();
      t_rst_offset();
      t_en_offset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule